// File: doc/BRIEF.md
# Pairing Loop Command Sequencer

This block is the control half of a bit-serial pairing evaluator. It holds no field values. It walks the bits of a loop scalar and sends a stream of commands to external arithmetic units. These units keep the accumulator `f` and the running point `V`. The block sends one command at a time and waits for a completion handshake before it moves on. The order of the commands depends only on the scalar and never on the input points, so the timing of an evaluation does not depend on the data.

After a start pulse, the block finds the index `t` of the highest set bit of the scalar. It then issues two set-up commands: set `f` to one, and copy `P` into `V`. Next it runs the iterations for bit indices `t-1` down to `0`. Each iteration squares `f`, evaluates the tangent line at `V`, multiplies `f` by that line and doubles `V`. For a set bit at an index other than zero, it then evaluates the chord line through `V` and `P`, multiplies `f` by that line and adds `P` to `V`. The loop leaves straight after the doubling at index zero. The final powering and any inversion are handled by the host.

States: `ST_IDLE`, `ST_INIT_F`, `ST_INIT_V`, `ST_SQR`, `ST_TAN`, `ST_MUL_T`, `ST_DBL`, `ST_CHORD`, `ST_MUL_C`, `ST_ADD`, `ST_DONE`. Transitions:
- `ST_IDLE` goes to `ST_INIT_F` on `start`.
- Each command state advances on `op_done`. The set-up and inner orders are `ST_INIT_F`→`ST_INIT_V` and `ST_SQR`→`ST_TAN`→`ST_MUL_T`→`ST_DBL`, then `ST_CHORD`→`ST_MUL_C`→`ST_ADD`.
- `ST_INIT_V` goes to `ST_DONE` when the scalar is at most 1, and to `ST_SQR` otherwise.
- `ST_DBL` goes to `ST_DONE` at index zero, to `ST_CHORD` on a set bit, and otherwise back to `ST_SQR` with the index lowered by one.
- `ST_ADD` goes back to `ST_SQR` with the index lowered by one.
- `ST_DONE` goes to `ST_IDLE` after one cycle.

Top module: `pairing_loop_seq`

## Requirements
- R1: While reset is active, and in the first cycle after it is released, `cmd_valid`, `busy` and `done` are all 0.
- R2: A `start` seen in `ST_IDLE` latches `scalar`. In the next cycle `busy`=1, `cmd_valid`=1 and `cmd_op`=0 (set `f` to one). That command is followed by `cmd_op`=1 (set `V` to `P`).
- R3: A command is held, with `cmd_op` stable and `cmd_valid`=1, until `op_done`=1 in a cycle. The next command, if there is one, appears in the following cycle.
- R4: For each bit index `i` from `t-1` down to `0`, where `t` is the index of the highest set bit, the block issues `cmd_op` 2 (square `f`), 3 (tangent line), 4 (multiply `f` by line) and 5 (double `V`), in that order.
- R5: For an index `i` other than zero with scalar bit `i` = 1, the doubling is followed by `cmd_op` 6 (chord line), then 4, then 7 (add `P` to `V`).
- R6: After the doubling at index zero, no chord, multiply or add command is issued, whatever the value of bit zero.
- R7: A scalar of 0 or 1 produces only the two set-up commands before finishing.
- R8: One cycle after the last command completes, `done`=1 for exactly one cycle with `busy`=0 and `cmd_valid`=0. The block is then idle.
- R9: A `start` while `busy`=1 is ignored. The command trace of the evaluation in progress is unchanged.
- R10: An `op_done` while `cmd_valid`=0 is ignored and starts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an evaluation (taken in idle only) |
| scalar | input | N | Loop scalar, sampled with `start` |
| op_done | input | 1 | Completion of the current command |
| cmd_valid | output | 1 | A command is presented |
| cmd_op | output | 3 | Command code (0 to 7, see R2, R4, R5) |
| busy | output | 1 | An evaluation is in progress |
| done | output | 1 | One-cycle pulse at the end of an evaluation |

## Verification
The assertions check the handshake properties on every cycle:
- a presented command stays stable until it completes;
- square is followed by tangent, chord by multiply, and the first set-up command by the second;
- a start from idle shows up at once as the first set-up command;
- the done pulse lasts one cycle, and no command is presented while idle.

Whether the whole trace matches the bits of the scalar can only be shown by the bench scenarios. These are: the scan from the highest set bit, the chord steps only on set bits above index zero, the early exit at index zero, the short path for scalars of 0 and 1, and a start ignored in mid-run.

// File: rtl/pairing_loop_pkg.sv
package pairing_loop_pkg;

    typedef enum logic [2:0] {
        OP_INIT_F = 3'd0,
        OP_INIT_V = 3'd1,
        OP_SQR    = 3'd2,
        OP_TAN    = 3'd3,
        OP_MULL   = 3'd4,
        OP_DBL    = 3'd5,
        OP_CHORD  = 3'd6,
        OP_ADD    = 3'd7
    } seq_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_INIT_F,
        ST_INIT_V,
        ST_SQR,
        ST_TAN,
        ST_MUL_T,
        ST_DBL,
        ST_CHORD,
        ST_MUL_C,
        ST_ADD,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/pairing_loop_msb.sv
module pairing_loop_msb #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     value,
    output logic [IDX_W-1:0] top_idx,
    output logic             gt_one
);
    logic [N-1:0][IDX_W-1:0] stage;

    // Ripple priority chain: each stage keeps the highest set bit seen so far.
    generate
        for (genvar k = 0; k < N; k++) begin : g_chain
            if (k == 0) begin : g_first
                assign stage[k] = '0;
            end else begin : g_rest
                assign stage[k] = value[k] ? IDX_W'(k) : stage[k-1];
            end
        end
    endgenerate

    assign top_idx = stage[N-1];
    assign gt_one  = |value[N-1:1];
endmodule

// File: rtl/pairing_loop_bitptr.sv
module pairing_loop_bitptr #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [N-1:0]     load_val,
    input  logic [IDX_W-1:0] load_top,
    input  logic             step,
    output logic             cur_bit,
    output logic             at_zero
);
    logic [N-1:0]     bits_q;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
            idx_q  <= '0;
        end else if (load) begin
            bits_q <= load_val;
            idx_q  <= (load_top == '0) ? '0 : load_top - IDX_W'(1);
        end else if (step) begin
            idx_q  <= idx_q - IDX_W'(1);
        end
    end

    assign cur_bit = bits_q[idx_q];
    assign at_zero = (idx_q == '0);
endmodule

// File: rtl/pairing_loop_seq.sv
module pairing_loop_seq
    import pairing_loop_pkg::*;
#(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [N-1:0] scalar,
    input  logic         op_done,
    output logic         cmd_valid,
    output logic [2:0]   cmd_op,
    output logic         busy,
    output logic         done
);
    localparam int IDX_W = $clog2(N);

    seq_state_e       state_q, state_d;
    logic [IDX_W-1:0] top_idx;
    logic             gt_one, long_q;
    logic             load, step, cur_bit, at_zero;

    pairing_loop_msb #(.N(N), .IDX_W(IDX_W)) u_msb (
        .value   (scalar),
        .top_idx (top_idx),
        .gt_one  (gt_one)
    );

    pairing_loop_bitptr #(.N(N), .IDX_W(IDX_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (scalar),
        .load_top (top_idx),
        .step     (step),
        .cur_bit  (cur_bit),
        .at_zero  (at_zero)
    );

    assign load = (state_q == ST_IDLE) && start;
    assign step = op_done && (((state_q == ST_DBL) && !at_zero && !cur_bit)
                              || (state_q == ST_ADD));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            long_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load) long_q <= gt_one;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start)   state_d = ST_INIT_F;
            ST_INIT_F: if (op_done) state_d = ST_INIT_V;
            ST_INIT_V: if (op_done) state_d = long_q ? ST_SQR : ST_DONE;
            ST_SQR:    if (op_done) state_d = ST_TAN;
            ST_TAN:    if (op_done) state_d = ST_MUL_T;
            ST_MUL_T:  if (op_done) state_d = ST_DBL;
            ST_DBL: begin
                if (op_done) begin
                    if (at_zero)      state_d = ST_DONE;
                    else if (cur_bit) state_d = ST_CHORD;
                    else              state_d = ST_SQR;
                end
            end
            ST_CHORD:  if (op_done) state_d = ST_MUL_C;
            ST_MUL_C:  if (op_done) state_d = ST_ADD;
            ST_ADD:    if (op_done) state_d = ST_SQR;
            ST_DONE:                state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        cmd_valid = 1'b1;
        cmd_op    = OP_INIT_F;
        busy      = 1'b1;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:   begin cmd_valid = 1'b0; busy = 1'b0; end
            ST_INIT_F: cmd_op = OP_INIT_F;
            ST_INIT_V: cmd_op = OP_INIT_V;
            ST_SQR:    cmd_op = OP_SQR;
            ST_TAN:    cmd_op = OP_TAN;
            ST_MUL_T:  cmd_op = OP_MULL;
            ST_DBL:    cmd_op = OP_DBL;
            ST_CHORD:  cmd_op = OP_CHORD;
            ST_MUL_C:  cmd_op = OP_MULL;
            ST_ADD:    cmd_op = OP_ADD;
            ST_DONE:   begin cmd_valid = 1'b0; busy = 1'b0; done = 1'b1; end
            default:   begin cmd_valid = 1'b0; busy = 1'b0; end
        endcase
    end
endmodule

// File: rtl/pairing_loop_seq_chk.sv
module pairing_loop_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       op_done,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic       busy,
    input logic       done
);
    p_start_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done) |=> (busy && cmd_valid && cmd_op == 3'd0));

    p_init_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd0 && op_done) |=> (cmd_valid && cmd_op == 3'd1));

    p_hold_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !op_done) |=> (cmd_valid && $stable(cmd_op)));

    p_sqr_then_tan_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd2 && op_done) |=> (cmd_valid && cmd_op == 3'd3));

    p_after_dbl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd5 && op_done)
        |=> (done || (cmd_valid && (cmd_op == 3'd2 || cmd_op == 3'd6))));

    p_chord_then_mul_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd6 && op_done) |=> (cmd_valid && cmd_op == 3'd4));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !cmd_valid) ##1 (!done && !busy));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cmd_valid);
endmodule

bind pairing_loop_seq pairing_loop_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op_done   (op_done),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .busy      (busy),
    .done      (done)
);

// File: tb/sim_pairing_loop_seq.sv
module sim_pairing_loop_seq;
    localparam int N      = 16;
    localparam int CLK_PD = 10;
    localparam int NV     = 7;
    localparam logic [N-1:0] VEC_N [0:NV-1] =
        '{16'h0002, 16'hFFFF, 16'h8001, 16'hA5A5, 16'h0003, 16'h0001, 16'h0000};
    localparam int VEC_LAT [0:NV-1] = '{0, 1, 2, 0, 3, 1, 0};
    localparam int VEC_INJ [0:NV-1] = '{-1, -1, 5, -1, -1, -1, -1};

    logic clk = 0, rst_n = 0, start = 0, op_done = 0;
    logic [N-1:0] scalar = '0;
    logic cmd_valid, busy, done;
    logic [2:0] cmd_op;

    int n_tests = 0, n_fail = 0, cyc = 0;
    int exp_tr [0:255];
    int got_tr [0:255];
    int exp_len, got_len;

    always #(CLK_PD/2) clk = ~clk;

    pairing_loop_seq #(.N(N)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .scalar(scalar),
        .op_done(op_done), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .busy(busy), .done(done)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic build_exp(input logic [N-1:0] n);
        int t;
        t = 0;
        for (int k = 0; k < N; k++) if (n[k]) t = k;
        exp_len = 0;
        exp_tr[exp_len++] = 0;
        exp_tr[exp_len++] = 1;
        for (int i = t - 1; i >= 0; i--) begin
            exp_tr[exp_len++] = 2; exp_tr[exp_len++] = 3;
            exp_tr[exp_len++] = 4; exp_tr[exp_len++] = 5;
            if (i == 0) break;
            if (n[i]) begin
                exp_tr[exp_len++] = 6; exp_tr[exp_len++] = 4; exp_tr[exp_len++] = 7;
            end
        end
    endtask

    task automatic run_vec(input logic [N-1:0] n, input int lat, input int inj);
        bit stable_ok, seen_done;
        int guard, mis, k0;
        logic [2:0] held;
        build_exp(n);
        @(negedge clk);
        scalar = n; start = 1;
        @(negedge clk);
        start = 0;
        check(busy && cmd_valid && cmd_op == 3'd0, "R2 first command", int'(cmd_op), 0);
        got_len = 0; stable_ok = 1; seen_done = 0; guard = 0;
        while (!seen_done && guard < 2000) begin
            guard++;
            if (done) begin
                seen_done = 1;
            end else if (cmd_valid) begin
                held = cmd_op;
                for (int w = 0; w < lat + (got_len % 2); w++) begin
                    @(negedge clk);
                    if (!cmd_valid || cmd_op != held) stable_ok = 0;
                end
                op_done = 1;
                if (got_len == inj) begin start = 1; scalar = 16'h0003; end
                got_tr[got_len++] = int'(cmd_op);
                @(negedge clk);
                op_done = 0; start = 0;
            end else begin
                @(negedge clk);
            end
        end
        check(stable_ok, "R3 command held until op_done", int'(stable_ok), 1);
        mis = -1;
        for (int k = 0; k < exp_len; k++)
            if (mis < 0 && (k >= got_len || got_tr[k] != exp_tr[k])) mis = k;
        k0 = (mis < 0) ? 0 : mis;
        check(mis < 0 && got_len == exp_len,
              $sformatf("R4 R5 R6 R7 R9 trace n=%h len=%0d/%0d idx=%0d", n, got_len, exp_len, k0),
              (mis < 0) ? got_len : ((k0 < got_len) ? got_tr[k0] : -1),
              (mis < 0) ? exp_len : exp_tr[k0]);
        check(seen_done && !busy && !cmd_valid, "R8 done pulse", int'(busy), 0);
        @(negedge clk);
        check(!done && !busy && !cmd_valid, "R8 done one cycle then idle", int'(done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!cmd_valid && !busy && !done, "R1 in reset", int'({cmd_valid, busy, done}), 0);
        rst_n = 1;
        @(negedge clk);
        check(!cmd_valid && !busy && !done, "R1 after reset", int'({cmd_valid, busy, done}), 0);

        for (int v = 0; v < NV; v++) run_vec(VEC_N[v], VEC_LAT[v], VEC_INJ[v]);

        // R10: stray op_done in idle starts nothing
        @(negedge clk); op_done = 1;
        @(negedge clk); op_done = 0;
        check(!cmd_valid && !busy, "R10 op_done idle ignored", int'(busy), 0);
        @(negedge clk);
        check(!cmd_valid && !busy && !done, "R10 still idle", int'(cmd_valid), 0);

        // R6: bit zero set with only two bits, no add at index zero
        run_vec(16'h0003, 0, -1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule